// File: doc/BRIEF.md
# Pairable Eight-Channel Pulse-Width Modulator

This block produces eight pulse-width modulated outputs, one per channel. Each channel owns a free-standing counter, an active period value and an active duty value. Software writes new period and duty values into per-channel buffer registers through a narrow write port. A running channel takes the buffered values only when its counter comes back to zero, so a waveform never shows a half-updated period. Each channel can be switched on and off by itself and has its own output polarity. It can run left-aligned, with a sawtooth count, or center-aligned, with a triangular count. It also has a clock-enable input that stands in for a prescaler.

Channels are grouped in fixed pairs (1:0, 3:2, 5:4, 7:6). Setting a pair's join bit turns the two 8-bit channels into one 16-bit channel, which gives any mix from eight 8-bit channels down to four 16-bit ones. An emergency shutdown input drives every output to its inactive level at once. The counters keep running during shutdown, so the waveforms resume in phase once it is released.

Top module: `pwm_bank`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at the rising edge into the buffer of channel `wr_ch`. `wr_fld`=0 selects the period buffer and `wr_fld`=1 the duty buffer. While a channel is disabled it copies both buffers into its active values on every edge, so enabling it two or more cycles after the last write starts at count 0 with the latest values.
- R2: In left-aligned mode (`ch_ctr` bit 0) an enabled channel with period P>0 counts 0,1,…,P-1 and then back to 0, one step per ticked edge. The output is active while the count is below the duty D.
- R3: In center-aligned mode (`ch_ctr` bit 1) the count rises 0…P-1, holds P-1 for one more tick, falls to 0 and holds 0 for one tick. The waveform period is therefore 2P ticks, and the output is active while count < D.
- R4: Buffer writes made while a channel runs leave its active period and duty unchanged until its counter returns to 0. That is the wrap in left mode and the bottom turn in center mode.
- R5: A duty of 0 gives a constant inactive output. A duty greater than or equal to the period gives a constant active output.
- R6: `ch_pol` bit 1 makes the active level high and bit 0 makes it low. The inactive level is always the inverse of the polarity bit.
- R7: A disabled channel outputs its inactive level and holds its counter at 0. After reset all channels are disabled.
- R8: A channel's counter advances only on edges where its `ch_tick` bit is high.
- R9: With `pair_cat[p]` set, channels 2p and 2p+1 form one 16-bit channel. Its period is {period[2p], period[2p+1]} and its duty is {duty[2p], duty[2p+1]}, with the odd channel as the low byte. The odd channel's enable, polarity, mode and tick control it, and its output appears on `pwm_out[2p+1]`. `pwm_out[2p]` is held at channel 2p's inactive level.
- R10: While `shutdown` is high, every output is at its inactive level in the same cycle, and the channel counters keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Buffer write strobe |
| wr_ch | input | 3 | Channel index of the write |
| wr_fld | input | 1 | 0 = period buffer, 1 = duty buffer |
| wr_data | input | 8 | Value written |
| ch_en | input | 8 | Per-channel enable |
| ch_pol | input | 8 | Per-channel polarity (1 = active high) |
| ch_ctr | input | 8 | Per-channel mode (1 = center-aligned) |
| ch_tick | input | 8 | Per-channel count enable |
| pair_cat | input | 4 | Per-pair join into a 16-bit channel |
| shutdown | input | 1 | Emergency force to inactive level |
| pwm_out | output | 8 | Channel outputs |

## Verification
On every cycle the assertions check several properties. The count stays below the active period. A counter without a tick does not move. A freshly enabled channel starts at zero, and the active period changes only at count zero. A joined pair keeps its even output idle, and shutdown forces every output inactive. Only the bench scenarios can show that the actual waveform sequence matches the left and center count patterns for each period and duty. The same holds for correct timing of mid-run buffer updates, 16-bit joining with the byte order, and the phase of the waveform after shutdown is released.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    // Field select of a buffer write
    typedef enum logic {
        FLD_PERIOD = 1'b0,
        FLD_DUTY   = 1'b1
    } fld_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int W   = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CW-1:0]           wr_ch,
    input  logic                    wr_fld,
    input  logic [W-1:0]            wr_data,
    output logic [NCH-1:0][W-1:0]   per_buf,
    output logic [NCH-1:0][W-1:0]   duty_buf
);
    typedef struct packed {
        logic [NCH-1:0][W-1:0] per;
        logic [NCH-1:0][W-1:0] duty;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (wr_fld == FLD_DUTY) d.duty[wr_ch] = wr_data;
            else                    d.per[wr_ch]  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign per_buf  = q.per;
    assign duty_buf = q.duty;

    // R1
    buf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fld == FLD_DUTY) |=> (q.duty[$past(wr_ch)] == $past(wr_data)));
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         ctr,
    input  logic [W-1:0] per_buf,
    input  logic [W-1:0] duty_buf,
    output logic         act
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic [W-1:0] per;
        logic [W-1:0] duty;
    } st_t;

    st_t d, q;
    logic top_hit;

    assign top_hit = (q.per == '0) || (q.cnt == q.per - 1'b1);

    always_comb begin
        d = q;
        if (!en) begin
            d.cnt  = '0;
            d.down = 1'b0;
            d.per  = per_buf;
            d.duty = duty_buf;
        end else if (tick) begin
            if (!ctr) begin
                d.down = 1'b0;
                if (top_hit) begin
                    d.cnt  = '0;
                    d.per  = per_buf;
                    d.duty = duty_buf;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else if (!q.down) begin
                if (top_hit) d.down = 1'b1;
                else         d.cnt  = q.cnt + 1'b1;
            end else begin
                if (q.cnt == '0) begin
                    d.down = 1'b0;
                    d.per  = per_buf;
                    d.duty = duty_buf;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act = en && (q.cnt < q.duty);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.per != '0) |-> (q.cnt < q.per));
    // R8
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(q.cnt));
    // R7
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (q.cnt == '0));
    // R4
    reload_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && q.per != $past(q.per)) |-> (q.cnt == '0));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           en,
    input  logic [1:0]           pol,
    input  logic [1:0]           ctr,
    input  logic [1:0]           tick,
    input  logic                 cat,
    input  logic                 shutdown,
    input  logic [1:0][W-1:0]    per_buf,
    input  logic [1:0][W-1:0]    duty_buf,
    output logic [1:0]           out
);
    localparam int WW = 2 * W;

    logic [1:0] act_n;
    logic       act_w;

    for (genvar i = 0; i < 2; i++) begin : g_narrow
        pwm_core #(.W(W)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en[i] && !cat),
            .tick     (tick[i]),
            .ctr      (ctr[i]),
            .per_buf  (per_buf[i]),
            .duty_buf (duty_buf[i]),
            .act      (act_n[i])
        );
    end

    pwm_core #(.W(WW)) u_wide (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en[1] && cat),
        .tick     (tick[1]),
        .ctr      (ctr[1]),
        .per_buf  ({per_buf[0], per_buf[1]}),
        .duty_buf ({duty_buf[0], duty_buf[1]}),
        .act      (act_w)
    );

    always_comb begin
        out[1] = (!shutdown && (cat ? act_w : act_n[1])) ? pol[1] : ~pol[1];
        out[0] = (!shutdown && !cat && act_n[0])         ? pol[0] : ~pol[0];
    end

    // R9
    cat_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cat |-> (out[0] == ~pol[0]));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
    parameter int NCH = 8,
    parameter int W   = 8,
    localparam int CW    = $clog2(NCH),
    localparam int NPAIR = NCH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_ch,
    input  logic              wr_fld,
    input  logic [W-1:0]      wr_data,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_pol,
    input  logic [NCH-1:0]    ch_ctr,
    input  logic [NCH-1:0]    ch_tick,
    input  logic [NPAIR-1:0]  pair_cat,
    input  logic              shutdown,
    output logic [NCH-1:0]    pwm_out
);
    logic [NCH-1:0][W-1:0] per_buf;
    logic [NCH-1:0][W-1:0] duty_buf;

    pwm_regs #(.NCH(NCH), .W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_fld   (wr_fld),
        .wr_data  (wr_data),
        .per_buf  (per_buf),
        .duty_buf (duty_buf)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm_pair #(.W(W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[2*p+1:2*p]),
            .pol      (ch_pol[2*p+1:2*p]),
            .ctr      (ch_ctr[2*p+1:2*p]),
            .tick     (ch_tick[2*p+1:2*p]),
            .cat      (pair_cat[p]),
            .shutdown (shutdown),
            .per_buf  (per_buf[2*p+1:2*p]),
            .duty_buf (duty_buf[2*p+1:2*p]),
            .out      (pwm_out[2*p+1:2*p])
        );
    end

    // R10
    shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (pwm_out == ~ch_pol));
    // R7
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> (pwm_out == ~ch_pol));
endmodule

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_ch = '0;
    logic       wr_fld = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] ch_en = '0;
    logic [7:0] ch_pol = '1;
    logic [7:0] ch_ctr = '0;
    logic [7:0] ch_tick = '1;
    logic [3:0] pair_cat = '0;
    logic       shutdown = 1'b0;
    logic [7:0] pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank i_pwm_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_fld(wr_fld),
        .wr_data(wr_data), .ch_en(ch_en), .ch_pol(ch_pol), .ch_ctr(ch_ctr),
        .ch_tick(ch_tick), .pair_cat(pair_cat), .shutdown(shutdown), .pwm_out(pwm_out)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_cnt(int j, int per, bit ctr);
        int m;
        if (per == 0) return 0;
        if (!ctr) return j % per;
        m = j % (2 * per);
        return (m < per) ? m : (2 * per - 1 - m);
    endfunction

    task automatic wr(int ch, bit fld, int val);
        wr_en = 1'b1; wr_ch = 3'(ch); wr_fld = fld; wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_case(int ch, int per, int duty, bit ctr, bit pol, int n,
                            int sd_lo, int sd_hi, string req);
        int c;
        logic e;
        ch_en = '0;
        wr(ch, 1'b0, per);
        wr(ch, 1'b1, duty);
        @(negedge clk);
        ch_pol[ch] = pol; ch_ctr[ch] = ctr; ch_en[ch] = 1'b1;
        for (int j = 0; j < n; j++) begin
            shutdown = (j >= sd_lo && j <= sd_hi);
            #1;
            c = exp_cnt(j, per, ctr);
            e = (c < duty) ? pol : ~pol;
            if (shutdown) e = ~pol;
            chk(req, pwm_out[ch], e);
            if (shutdown) chk("R10", pwm_out[(ch + 1) % 8], ~ch_pol[(ch + 1) % 8]);
            @(negedge clk);
        end
        shutdown = 1'b0; ch_en[ch] = 1'b0; ch_pol[ch] = 1'b1; ch_ctr[ch] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c, t;
        logic e;
        string tag;
        repeat (3) @(negedge clk);
        // R7: after reset every channel idles at its inactive level
        for (int k = 0; k < 8; k++) chk("R7", pwm_out[k], 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 8; k++) chk("R7", pwm_out[k], 1'b0);

        // R1: the latest buffer values written while disabled are used
        wr(7, 1'b0, 9); wr(7, 1'b1, 7);
        run_case(7, 4, 1, 1'b0, 1'b1, 12, 99, 99, "R1");

        // Sweep of small periods, all duties, both modes and polarities
        for (int per = 1; per <= 4; per++)
            for (int duty = 0; duty <= per + 1; duty++)
                for (int m = 0; m < 4; m++) begin
                    tag = (duty == 0 || duty >= per) ? "R5" :
                          ((m & 2) == 0 ? "R6" : ((m & 1) ? "R3" : "R2"));
                    run_case(2, per, duty, m[0], m[1], 4 * per + 1, 99, 99, tag);
                end

        // R10: shutdown window mid-run, phase kept afterwards
        run_case(4, 5, 3, 1'b1, 1'b1, 25, 6, 9, "R10");
        run_case(0, 6, 2, 1'b0, 1'b0, 20, 3, 4, "R10");

        // R4: mid-run buffer writes take effect only at count zero
        wr(5, 1'b0, 5); wr(5, 1'b1, 2);
        @(negedge clk);
        ch_en[5] = 1'b1;
        for (int j = 0; j < 15; j++) begin
            #1;
            if (j < 5) e = ((j % 5) < 2);
            else       e = (((j - 5) % 3) < 1);
            chk("R4", pwm_out[5], e);
            if (j == 1) begin wr_en = 1'b1; wr_ch = 3'd5; wr_fld = 1'b1; wr_data = 8'd1; end
            if (j == 2) begin wr_en = 1'b1; wr_ch = 3'd5; wr_fld = 1'b0; wr_data = 8'd3; end
            if (j == 3) wr_en = 1'b0;
            @(negedge clk);
        end
        ch_en[5] = 1'b0;
        @(negedge clk);

        // R8: counter advances only on ticked edges
        wr(6, 1'b0, 3); wr(6, 1'b1, 1);
        @(negedge clk);
        ch_en[6] = 1'b1;
        t = 0;
        for (int j = 0; j < 18; j++) begin
            #1;
            chk("R8", pwm_out[6], (t % 3) < 1);
            ch_tick[6] = (j % 3 != 1);
            if (j % 3 != 1) t++;
            @(negedge clk);
        end
        ch_en[6] = 1'b0; ch_tick = '1;
        @(negedge clk);

        // R9: pair 1 joined, period 0x0102 = 258, duty 0x0081 = 129
        wr(2, 1'b0, 8'h01); wr(3, 1'b0, 8'h02);
        wr(2, 1'b1, 8'h00); wr(3, 1'b1, 8'h81);
        pair_cat[1] = 1'b1;
        @(negedge clk);
        ch_en[2] = 1'b1; ch_en[3] = 1'b1;
        for (int j = 0; j < 600; j++) begin
            #1;
            c = j % 258;
            chk("R9", pwm_out[3], c < 129);
            chk("R9", pwm_out[2], 1'b0);
            @(negedge clk);
        end
        ch_en = '0; pair_cat = '0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule